// File: doc/BRIEF.md
# Keyed Software Watchdog Timer

This block is a watchdog that software keeps alive by writing a two-byte key to a dedicated service register. The first byte, 0x55, arms the block. The second byte, 0xAA, completes the key and reloads the timeout counter with the programmed period. If a complete key does not arrive before the counter runs out, the block raises a reset request. The request stays high until the block is itself reset.

A single enable bit gates the whole function. While the bit is low, the counter holds the full period and no key byte is accepted. The period comes in as a plain cycle count. A reset controller outside this block acts on the request.

Top module: `wdg_keyed_watchdog`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `rst_req`, clears the armed state and loads the counter with `period`.
- R2: With `enable` high and no service, `rst_req` goes high at the (P+1)-th rising edge that samples `enable` high, where P is `period`. Counting starts from the last reload.
- R3: A service is a write of 0x55 followed later by a write of 0xAA. A write is an edge with `wr_en` and `wr_sel` both high. The edge that takes the 0xAA reloads the counter, and with no further service `rst_req` then rises P+1 edges later.
- R4: A write with `wr_sel` low does not arm the block and does not reload the counter.
- R5: A 0xAA write with no pending 0x55 has no effect on the counter.
- R6: A write of any value other than 0x55 or 0xAA clears the armed state without reloading, so a following 0xAA does nothing.
- R7: Several 0x55 writes in a row keep the block armed, and a later 0xAA completes the service.
- R8: An 0xAA that completes a service uses up the armed state, so a second 0xAA straight after it does not reload.
- R9: While `enable` is low, the counter does not run, the armed state is cleared and key writes are ignored. Raising `enable` again starts a fresh full period.
- R10: Once `rst_req` is high, it stays high until `rst` is asserted, whatever `enable` and the key writes do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Selects the service register for this write |
| wr_data | input | 8 | Write data byte |
| enable | input | 1 | Watchdog enable bit from the protection control register |
| period | input | CNT_W | Timeout period in clock cycles |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench measures the timeout edge against a period sweep from 0 to 7. This shows whether the counter is off by one and whether the load is correct.

Key streams are then applied that differ in a single detail:
- a clean 0x55/0xAA pair;
- a lone 0xAA;
- a foreign byte between the two keys;
- repeated 0x55 bytes;
- a doubled 0xAA;
- writes with the select low;
- a key split by an enable drop.

Each stream either moves the timeout edge by a computed amount or leaves it where it was. This separates a correct key decoder from one that is too strict or too loose.

Further cases cover keep-alive over many periods, a long pause with `enable` low, and the sticky request.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] KEY_ARM_BYTE  = 8'h55;
    localparam logic [7:0] KEY_FIRE_BYTE = 8'hAA;

    typedef enum logic [1:0] {
        KEY_NONE  = 2'd0,
        KEY_ARM   = 2'd1,
        KEY_FIRE  = 2'd2,
        KEY_OTHER = 2'd3
    } key_kind_e;

    typedef struct packed {
        logic      valid;
        key_kind_e kind;
    } key_evt_t;

    function automatic key_evt_t decode_write(input logic wr, input logic sel,
                                              input logic [7:0] data);
        key_evt_t e;
        e.valid = wr && sel;
        if (!e.valid)                e.kind = KEY_NONE;
        else if (data == KEY_ARM_BYTE)  e.kind = KEY_ARM;
        else if (data == KEY_FIRE_BYTE) e.kind = KEY_FIRE;
        else                         e.kind = KEY_OTHER;
        return e;
    endfunction

endpackage

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  key_evt_t evt,
    output logic     service
);

    logic armed_q;

    always_comb begin
        service = enable && evt.valid && (evt.kind == KEY_FIRE) && armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            armed_q <= 1'b0;
        end else if (evt.valid) begin
            case (evt.kind)
                KEY_ARM:  armed_q <= 1'b1;
                default:  armed_q <= 1'b0;
            endcase
        end
    end

    // R9: a low enable leaves the tracker disarmed
    a_r9_disarm_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !armed_q);

    // R5: a lone fire byte never produces a service
    a_r5_fire_needs_arm: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.kind == KEY_FIRE && !armed_q) |-> !service);

    // R8: a service always leaves the tracker disarmed
    a_r8_fire_consumes: assert property (@(posedge clk) disable iff (rst)
        service |=> !armed_q);

endmodule

// File: rtl/wdg_timeout_ctr.sv
module wdg_timeout_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             reload,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= period;
        end else if (reload) begin
            cnt_q <= period;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    always_comb begin
        expire = enable && !reload && (cnt_q == CNT_ZERO);
    end

    // R3: a service loads the full period
    a_r3_reload_full: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == $past(period)));

    // R2: an enabled, unserviced counter steps down by exactly one
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (enable && !reload && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R9: with enable low the count is parked at the period
    a_r9_parked: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt_q == $past(period)));

endmodule

// File: rtl/wdg_keyed_watchdog.sv
module wdg_keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    output logic             rst_req
);

    key_evt_t evt;
    logic     service;
    logic     expire;
    logic     req_q;

    always_comb begin
        evt = decode_write(wr_en, wr_sel, wr_data);
    end

    wdg_key_seq u_key (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .evt     (evt),
        .service (service)
    );

    wdg_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .reload (service),
        .period (period),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst)         req_q <= 1'b0;
        else if (expire) req_q <= 1'b1;
    end

    assign rst_req = req_q;

    // R10: the request never drops without a reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);

    // R2: a new request only follows an enabled cycle
    a_r2_rise_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(enable));

    // R4: writes to another register never service the watchdog
    a_r4_sel_gate: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |-> !service);

endmodule

// File: tb/wdg_keyed_watchdog_tb.sv
module wdg_keyed_watchdog_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] period = '0;
    logic             rst_req;

    int vectors = 0;
    int miscompares = 0;
    int edge_cnt = 0;
    int mark;
    int at;

    wdg_keyed_watchdog #(.CNT_W(CNT_W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .enable  (enable),
        .period  (period),
        .rst_req (rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    endtask

    task automatic start(input int p);
        period = CNT_W'(p);
        enable = 1'b0;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        enable = 1'b1;
        mark = edge_cnt;
    endtask

    task automatic wait_req(output int when);
        when = -1;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (rst_req) begin
                when = edge_cnt;
                break;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=0", edge_cnt);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset state, enable low for a while
        start(5);
        enable = 1'b0;
        check(rst_req == 1'b0, "R1 reset clear", rst_req, 0);
        for (int i = 0; i < 10; i++) tick();
        check(rst_req == 1'b0, "R1/R9 idle disabled", rst_req, 0);

        // R2: period sweep, timeout at P+1 enabled edges
        for (int p = 0; p < 8; p++) begin
            start(p);
            wait_req(at);
            check(at == mark + p + 1, "R2 timeout edge", at - mark, p + 1);
        end

        // R3: clean key at various periods
        for (int p = 4; p < 8; p++) begin
            start(p);
            tick(); tick();
            wr(1'b1, 8'h55);
            wr(1'b1, 8'hAA);
            mark = edge_cnt;
            wait_req(at);
            check(at == mark + p + 1, "R3 reload after key", at - mark, p + 1);
        end

        // R3: keep-alive over many periods
        start(5);
        for (int i = 0; i < 12; i++) begin
            wr(1'b1, 8'h55);
            wr(1'b1, 8'hAA);
            tick();
        end
        check(rst_req == 1'b0, "R3 keep alive", rst_req, 0);

        // R4: key written with select low
        start(7);
        wr(1'b0, 8'h55);
        wr(1'b0, 8'hAA);
        wait_req(at);
        check(at == mark + 8, "R4 sel low ignored", at - mark, 8);

        // R5: lone fire byte
        start(7);
        tick();
        wr(1'b1, 8'hAA);
        wait_req(at);
        check(at == mark + 8, "R5 lone AA", at - mark, 8);

        // R6: foreign byte between keys
        start(7);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h12);
        wr(1'b1, 8'hAA);
        wait_req(at);
        check(at == mark + 8, "R6 other byte disarms", at - mark, 8);

        start(7);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hAA);
        wait_req(at);
        check(at == mark + 8, "R6 zero byte disarms", at - mark, 8);

        // R7: repeated arm bytes
        start(7);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        mark = edge_cnt;
        wait_req(at);
        check(at == mark + 8, "R7 repeated 55", at - mark, 8);

        // R8: doubled fire byte
        start(7);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        mark = edge_cnt;
        wr(1'b1, 8'hAA);
        wait_req(at);
        check(at == mark + 8, "R8 second AA no reload", at - mark, 8);

        // R9: pause and restart from full period
        start(3);
        tick(); tick();
        enable = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        check(rst_req == 1'b0, "R9 paused", rst_req, 0);
        enable = 1'b1;
        mark = edge_cnt;
        wait_req(at);
        check(at == mark + 4, "R9 full period on re-enable", at - mark, 4);

        // R9: enable drop clears the armed state
        start(7);
        wr(1'b1, 8'h55);
        enable = 1'b0;
        tick();
        enable = 1'b1;
        mark = edge_cnt;
        wr(1'b1, 8'hAA);
        wait_req(at);
        check(at == mark + 8, "R9 drop disarms", at - mark, 8);

        // R9: arm byte written while disabled is ignored
        start(7);
        enable = 1'b0;
        wr(1'b1, 8'h55);
        enable = 1'b1;
        mark = edge_cnt;
        wr(1'b1, 8'hAA);
        wait_req(at);
        check(at == mark + 8, "R9 disabled write ignored", at - mark, 8);

        // R10: sticky request, cleared only by reset
        start(2);
        wait_req(at);
        check(rst_req == 1'b1, "R10 request raised", rst_req, 1);
        enable = 1'b0;
        wr(1'b1, 8'h55);
        enable = 1'b1;
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        for (int i = 0; i < 10; i++) tick();
        check(rst_req == 1'b1, "R10 request held", rst_req, 1);
        rst = 1'b1;
        tick();
        check(rst_req == 1'b0, "R1 reset clears request", rst_req, 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule